// File: doc/BRIEF.md
# Bit-Serial Adder

This block adds two unsigned operands of `WIDTH` bits one bit position per clock, starting at the least significant bit. A load strobe captures both operands into parallel-in shift registers. A start strobe then launches a run. Each clock, one bit of each operand feeds a carry-tracking state machine, and the resulting sum bit enters a collecting shift register. When the last sum bit is in place, the full result appears on the parallel output, together with the final carry, and a one-cycle done flag is raised.

The parameter `MOORE` chooses between two forms of the carry machine. With `MOORE = 0`, a two-state machine holds only the carry, and the sum bit is formed combinationally from the present carry and the two operand bits. With `MOORE = 1`, a four-state machine registers both the carry and the sum bit. Because the sum bit then trails by one clock, the run is one cycle longer: the collecting register skips the first cycle and shifts one cycle past the last operand bit. Both forms deliver the same result.

Top module: `bit_serial_adder`

## Requirements
- R1: While `rst_ni` is low, and after it is released, `sum_o`, `carry_o` and `done_o` are 0.
- R2: With `MOORE = 0`, when `done_o` is high, `sum_o` equals the low `WIDTH` bits of `a_i + b_i` as loaded, and `carry_o` equals bit `WIDTH` of that sum.
- R3: `done_o` is high for exactly one cycle. With `MOORE = 0` it rises `WIDTH` clock edges after the edge that samples `start_i`.
- R4: With `MOORE = 1`, the result equals the R2 result, and `done_o` rises `WIDTH + 1` edges after the edge that samples `start_i`.
- R5: `load_i` aborts any run in progress, and the next edge clears the carry state, so `carry_o` reads 0. No `done_o` follows until a new start.
- R6: `start_i` has no effect while a run is in progress, and the run finishes on its original schedule. `load_i` takes priority over `start_i` when both are high.
- R7: Between runs, `sum_o` holds its last value. In the cycle after `done_o`, `sum_o` is unchanged.
- R8: In the two-state carry machine, a clear carry becomes set only when both operand bits are 1. A set carry becomes clear only when both operand bits are 0. In every other case the carry is kept.
- R9: In the four-state machine, the registered sum bit equals the XOR of both operand bits and the carry from the previous cycle. The carry part of the state follows the full-adder carry-out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| load_i | input | 1 | Capture operands, clear carry, abort a run |
| a_i | input | WIDTH | Operand A, parallel |
| b_i | input | WIDTH | Operand B, parallel |
| start_i | input | 1 | Begin a serial addition when idle |
| sum_o | output | WIDTH | Parallel sum |
| carry_o | output | 1 | Final carry-out |
| done_o | output | 1 | One-cycle flag: sum valid |

## Verification
The bench goes after carry propagation across every bit position, using cases such as all-ones plus one and all-ones plus all-ones. A machine with a wrong carry transition returns a corrupted upper sum or a missing carry-out on these cases. Both forms run side by side on the same stimulus, and `done_o` is checked on every cycle of the run. A sum register shifted at the wrong time would show the four-state result shifted by one bit, or `done_o` a cycle early. A start pulse in the middle of a run, and a load that aborts a run while the carry is set, target designs that restart on a second start or keep a stale carry after a load.

// File: rtl/serad_pkg.sv
package serad_pkg;

  typedef enum logic {
    CY_CLR = 1'b0,
    CY_SET = 1'b1
  } cy2_st_e;

  // encoding {carry, sum}
  typedef enum logic [1:0] {
    C0_S0 = 2'b00,
    C0_S1 = 2'b01,
    C1_S0 = 2'b10,
    C1_S1 = 2'b11
  } cy4_st_e;

  function automatic logic [1:0] full_add(input logic x, input logic y, input logic ci);
    return {(x & y) | (ci & (x ^ y)), x ^ y ^ ci};
  endfunction

endpackage

// File: rtl/serad_piso.sv
module serad_piso #(
  parameter int WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [WIDTH-1:0] par_i,
  input  logic             shift_i,
  output logic             ser_o
);
  logic [WIDTH-1:0] q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      q <= '0;
    else if (load_i)  q <= par_i;
    else if (shift_i) q <= {1'b0, q[WIDTH-1:1]};
  end

  assign ser_o = q[0];
endmodule

// File: rtl/serad_sipo.sv
module serad_sipo #(
  parameter int WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             shift_i,
  input  logic             ser_i,
  output logic [WIDTH-1:0] par_o
);
  logic [WIDTH-1:0] q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      q <= '0;
    else if (shift_i) q <= {ser_i, q[WIDTH-1:1]};
  end

  assign par_o = q;
endmodule

// File: rtl/serad_carry_fsm.sv
module serad_carry_fsm
  import serad_pkg::*;
#(
  parameter bit MOORE = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic en_i,
  input  logic a_i,
  input  logic b_i,
  output logic sum_bit_o,
  output logic carry_o
);
  if (MOORE) begin : g_moore
    cy4_st_e st_q, st_d;

    assign st_d = cy4_st_e'(full_add(a_i, b_i, st_q[1]));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    st_q <= C0_S0;
      else if (clr_i) st_q <= C0_S0;
      else if (en_i)  st_q <= st_d;
    end

    assign sum_bit_o = st_q[0];
    assign carry_o   = st_q[1];

    p_moore_sum_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (en_i && !clr_i) |=> (sum_bit_o == ($past(a_i) ^ $past(b_i) ^ $past(carry_o))));
    p_moore_cy_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (en_i && !clr_i && a_i && b_i) |=> carry_o);
  end else begin : g_mealy
    cy2_st_e st_q, st_d;

    always_comb begin
      unique case (st_q)
        CY_CLR:  st_d = (a_i & b_i) ? CY_SET : CY_CLR;
        default: st_d = (a_i | b_i) ? CY_SET : CY_CLR;
      endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    st_q <= CY_CLR;
      else if (clr_i) st_q <= CY_CLR;
      else if (en_i)  st_q <= st_d;
    end

    assign carry_o   = (st_q == CY_SET);
    assign sum_bit_o = a_i ^ b_i ^ carry_o;

    p_mealy_set_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (en_i && !clr_i && !carry_o && !(a_i && b_i)) |=> !carry_o);
    p_mealy_keep_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (en_i && !clr_i && carry_o && (a_i || b_i)) |=> carry_o);
    p_mealy_go_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (en_i && !clr_i && (a_i == b_i)) |=> (carry_o == $past(a_i)));
  end

  p_clr_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !carry_o);
endmodule

// File: rtl/serad_ctrl.sv
module serad_ctrl #(
  parameter int WIDTH = 8,
  parameter bit MOORE = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  logic start_i,
  output logic go_o,
  output logic op_en_o,
  output logic sum_en_o,
  output logic done_o
);
  localparam int LAST  = WIDTH - 1 + (MOORE ? 1 : 0);
  localparam int CNT_W = $clog2(WIDTH + 1);

  logic             running_q, done_q;
  logic [CNT_W-1:0] cnt_q;
  logic             last;

  assign last     = (cnt_q == CNT_W'(LAST));
  assign go_o     = start_i & ~load_i & ~running_q;
  assign op_en_o  = running_q & (cnt_q < CNT_W'(WIDTH));
  // Moore output lags one cycle: skip the first sum shift
  assign sum_en_o = running_q & (!MOORE || (cnt_q != '0));
  assign done_o   = done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      running_q <= 1'b0;
      cnt_q     <= '0;
      done_q    <= 1'b0;
    end else if (load_i) begin
      running_q <= 1'b0;
      cnt_q     <= '0;
      done_q    <= 1'b0;
    end else if (go_o) begin
      running_q <= 1'b1;
      cnt_q     <= '0;
      done_q    <= 1'b0;
    end else if (running_q) begin
      done_q <= last;
      if (last) running_q <= 1'b0;
      else      cnt_q     <= cnt_q + CNT_W'(1);
    end else begin
      done_q <= 1'b0;
    end
  end

  p_done_pulse_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  p_run_on_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (running_q && !load_i && !last) |=> (running_q && cnt_q == $past(cnt_q) + CNT_W'(1)));
  p_load_abort_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (!running_q && !done_o));
  p_done_src_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> $past(running_q));
endmodule

// File: rtl/bit_serial_adder.sv
module bit_serial_adder #(
  parameter int WIDTH = 8,
  parameter bit MOORE = 1'b0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             start_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             carry_o,
  output logic             done_o
);
  logic go, op_en, sum_en;
  logic a_bit, b_bit, s_bit;

  serad_ctrl #(.WIDTH(WIDTH), .MOORE(MOORE)) u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (load_i),
    .start_i (start_i),
    .go_o    (go),
    .op_en_o (op_en),
    .sum_en_o(sum_en),
    .done_o  (done_o)
  );

  serad_piso #(.WIDTH(WIDTH)) u_op_a (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load_i),
    .par_i  (a_i),
    .shift_i(op_en),
    .ser_o  (a_bit)
  );

  serad_piso #(.WIDTH(WIDTH)) u_op_b (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load_i),
    .par_i  (b_i),
    .shift_i(op_en),
    .ser_o  (b_bit)
  );

  serad_carry_fsm #(.MOORE(MOORE)) u_fsm (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (load_i | go),
    .en_i     (op_en),
    .a_i      (a_bit),
    .b_i      (b_bit),
    .sum_bit_o(s_bit),
    .carry_o  (carry_o)
  );

  serad_sipo #(.WIDTH(WIDTH)) u_sum (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .shift_i(sum_en),
    .ser_i  (s_bit),
    .par_o  (sum_o)
  );

  p_hold_after_done_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> $stable(sum_o));
  p_reset_r1: assert property (@(posedge clk_i)
    !rst_ni |-> (sum_o == '0 && !carry_o && !done_o));
endmodule

// File: tb/bit_serial_adder_test.sv
`timescale 1ns/1ps
module bit_serial_adder_test;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic         load = 1'b0, start = 1'b0;
  logic [W-1:0] a = '0, b = '0;
  logic [W-1:0] sum_m, sum_q;
  logic         cy_m, cy_q, done_m, done_q;
  int           checks = 0, errors = 0;

  always #2 clk = ~clk;

  bit_serial_adder #(.WIDTH(W), .MOORE(1'b0)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .load_i(load), .a_i(a), .b_i(b),
    .start_i(start), .sum_o(sum_m), .carry_o(cy_m), .done_o(done_m));

  bit_serial_adder #(.WIDTH(W), .MOORE(1'b1)) uut_moore (
    .clk_i(clk), .rst_ni(rst_ni), .load_i(load), .a_i(a), .b_i(b),
    .start_i(start), .sum_o(sum_q), .carry_o(cy_q), .done_o(done_q));

  function automatic logic [W:0] ref_add(input logic [W-1:0] x, input logic [W-1:0] y);
    return {1'b0, x} + {1'b0, y};
  endfunction

  task automatic chk(input string req, input logic [W:0] act, input logic [W:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic add_pair(input logic [W-1:0] x, input logic [W-1:0] y, input bit poke);
    logic [W:0] e;
    e = ref_add(x, y);
    @(negedge clk); a = x; b = y; load = 1'b1;
    @(negedge clk); load = 1'b0; start = 1'b1;
    @(negedge clk); start = 1'b0;
    for (int k = 1; k <= W; k++) begin
      @(negedge clk);
      start = poke && (k == 2); // R6: ignored mid-run start
      if (k < W) chk("R3 early done", {{W{1'b0}}, done_m}, '0);
    end
    chk("R3 done rise", {{W{1'b0}}, done_m}, 1);
    chk("R2 sum", {1'b0, sum_m}, {1'b0, e[W-1:0]});
    chk("R2 carry", {{W{1'b0}}, cy_m}, {{W{1'b0}}, e[W]});
    chk("R4 moore early", {{W{1'b0}}, done_q}, '0);
    @(negedge clk);
    chk("R3 pulse", {{W{1'b0}}, done_m}, '0);
    chk("R4 moore done", {{W{1'b0}}, done_q}, 1);
    chk("R4 moore sum", {1'b0, sum_q}, {1'b0, e[W-1:0]});
    chk("R4 moore carry", {{W{1'b0}}, cy_q}, {{W{1'b0}}, e[W]});
    chk("R7 hold", {1'b0, sum_m}, {1'b0, e[W-1:0]});
    @(negedge clk);
    chk("R3 moore pulse", {{W{1'b0}}, done_q}, '0);
  endtask

  initial begin : main
    logic [W-1:0] keep_m, keep_q;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk("R1 sum", {1'b0, sum_m}, '0);
    chk("R1 done", {{W{1'b0}}, done_m | done_q}, '0);
    chk("R1 carry", {{W{1'b0}}, cy_m | cy_q}, '0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R1 after release", {1'b0, sum_q}, '0);

    add_pair('0, '0, 1'b0);
    add_pair('1, 8'd1, 1'b0);
    add_pair('1, '1, 1'b0);
    add_pair(8'h80, 8'h80, 1'b0);
    add_pair(8'hAA, 8'h55, 1'b0);
    add_pair(8'h7F, 8'h01, 1'b1); // R6
    add_pair(8'hC3, 8'h3D, 1'b1); // R6

    // R5: abort while carry is set
    @(negedge clk); a = '1; b = '1; load = 1'b1;
    @(negedge clk); load = 1'b0; start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (3) @(negedge clk);
    a = '0; b = '0; load = 1'b1;
    @(negedge clk); load = 1'b0;
    chk("R5 carry cleared", {{W{1'b0}}, cy_m | cy_q}, '0);
    for (int k = 0; k < W + 3; k++) begin
      @(negedge clk);
      chk("R5 no done", {{W{1'b0}}, done_m | done_q}, '0);
    end

    // R6: load and start together -> load wins, no run
    @(negedge clk); a = 8'h0F; b = 8'h01; load = 1'b1; start = 1'b1;
    @(negedge clk); load = 1'b0; start = 1'b0;
    for (int k = 0; k < W + 3; k++) begin
      @(negedge clk);
      chk("R6 load priority", {{W{1'b0}}, done_m | done_q}, '0);
    end

    add_pair(8'h01, 8'hFF, 1'b0);
    keep_m = sum_m; keep_q = sum_q;
    repeat (6) @(negedge clk);
    chk("R7 idle mealy", {1'b0, sum_m}, {1'b0, keep_m});
    chk("R7 idle moore", {1'b0, sum_q}, {1'b0, keep_q});

    for (int i = 0; i < 40; i++)
      add_pair(W'($urandom), W'($urandom), ($urandom % 4) == 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule